// File: doc/BRIEF.md
# Prescaled Time-Base Counter

This block is the time base of a peripheral timer. A prescaler divides the input clock and drives an up-counter. The up-counter runs from zero to a reload limit, returns to zero and raises an update event. Software sets the divider and the reload limit through a small register port. Each of those values is held in two registers. Software writes the pending copy, and the counting logic reads the active copy. The pending copy moves into the active copy only at an update event.

An update event happens in two ways: the counter wraps, or software forces one through the event register. A block bit in the control register suppresses both kinds. While the block bit is set, the counter still wraps, but the active values stay as they are and no flag is raised. A sticky update flag, masked by an interrupt enable, forms the interrupt output. The counter can be stopped, resumed and overwritten at any time.

Top module: `pscl_timebase`

## Requirements
- R1: After reset:
  - the counter reads 0;
  - the pending and active divider are 0;
  - the pending and active reload limit are all ones (0xFFFF);
  - run, block, interrupt enable and the update flag are all 0.
- R2: While run is set, the counter advances by one every (active divider + 1) clock cycles. A prescaler counter reaches the active divider and then restarts at 0.
- R3: When the counter equals the active reload limit at a prescaler tick, the counter returns to 0 and the prescaler counter restarts. If block is clear, this is an update event:
  - pending divider and reload limit copy into the active ones;
  - the update flag sets;
  - upd_pulse is high for the one cycle in which the counter first reads 0.
- R4: A write to the divider (address 4) or reload (address 5) register is returned by a read at once. Counting keeps using the old active values until the next update event.
- R5: Writing 1 to bit 0 of the event register (address 2) while block is clear forces an update event. After the following edge:
  - the counter reads 0;
  - the prescaler counter is 0;
  - the active values equal the pending ones;
  - the update flag is set;
  - upd_pulse is high for one cycle.
- R6: Writing the event bit while block is set has no effect. The counter, the active values, the flag and upd_pulse are unchanged.
- R7: With block set, a wrap still returns the counter to 0. It does not load the active values, set the update flag or pulse upd_pulse.
- R8: Control register (address 0) bit 0 is run. While run is clear the counter and the prescaler counter hold. Setting run again resumes from the held value. No other register changes.
- R9: A write to the count register (address 3) sets the counter to the written value on the next edge. This takes priority over a prescaler tick in the same cycle. The prescaler counter continues unaffected.
- R10: The update flag (status register, address 1, bit 0) stays set until software writes 0 to that bit. Writing 1 does nothing. An update event in the same cycle as a clearing write leaves the flag set.
- R11: upd_irq is high exactly while the update flag and the interrupt enable (control bit 2) are both set.
- R12: rd_data returns the register selected by rd_addr, combinationally:
  - control is {ie, block, run} in bits 2..0;
  - status is the flag in bit 0;
  - event reads 0;
  - count, divider and reload read the counter, the pending divider and the pending reload limit;
  - addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for rd_addr |
| count_o | output | 16 | Current counter value |
| upd_pulse | output | 1 | One-cycle update event marker |
| upd_irq | output | 1 | Update flag gated by interrupt enable |

## Verification
The bench drives divider changes while the counter is running and checks that the period stays at the old value until an update. A design that applied the new value at once would shorten or stretch the current period.

Forced updates are tried with block both clear and set. A design that ignored block would clear the counter and raise the flag when it should not. A design that skipped the prescaler restart would put the first tick after the update in the wrong cycle.

Writes to the count register are made on the same cycle as a tick, and flag clears on the same cycle as a wrap. Losing either priority shows up as a wrong counter value or a dropped flag.

// File: rtl/pscl_timebase.sv
module pscl_timebase #(
  parameter int W = 16,
  parameter logic [W-1:0] TOP_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] count_o,
  output logic         upd_pulse,
  output logic         upd_irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_EVT = 3'd2,
                         A_CNT  = 3'd3, A_DIV  = 3'd4, A_TOP = 3'd5;

  logic         run, blk, ie, uif, upd_q;
  logic [W-1:0] div_pre, top_pre, div_act, top_act, div_cnt, cnt;

  wire tick    = run && (div_cnt == div_act);
  wire wrap    = tick && (cnt == top_act);
  wire ug      = wr_en && (wr_addr == A_EVT) && wr_data[0] && !blk;
  wire upd_evt = ug || (wrap && !blk);
  wire wr_cnt  = wr_en && (wr_addr == A_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; blk <= 1'b0; ie <= 1'b0; uif <= 1'b0; upd_q <= 1'b0;
      div_pre <= '0; div_act <= '0; top_pre <= TOP_RST; top_act <= TOP_RST;
      div_cnt <= '0; cnt <= '0;
    end else begin
      upd_q <= upd_evt;

      if (ug || tick)      div_cnt <= '0;
      else if (run)        div_cnt <= div_cnt + 1'b1;

      if (wr_cnt)          cnt <= wr_data;
      else if (ug || wrap) cnt <= '0;
      else if (tick)       cnt <= cnt + 1'b1;

      if (upd_evt) begin
        div_act <= div_pre;
        top_act <= top_pre;
      end

      if (wr_en && wr_addr == A_DIV) div_pre <= wr_data;
      if (wr_en && wr_addr == A_TOP) top_pre <= wr_data;
      if (wr_en && wr_addr == A_CTRL) begin
        run <= wr_data[0];
        blk <= wr_data[1];
        ie  <= wr_data[2];
      end

      if (upd_evt)                                       uif <= 1'b1;
      else if (wr_en && wr_addr == A_STAT && !wr_data[0]) uif <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(W-3){1'b0}}, ie, blk, run};
      A_STAT:  rd_data = {{(W-1){1'b0}}, uif};
      A_CNT:   rd_data = cnt;
      A_DIV:   rd_data = div_pre;
      A_TOP:   rd_data = top_pre;
      default: rd_data = '0;
    endcase
  end

  assign count_o   = cnt;
  assign upd_pulse = upd_q;
  assign upd_irq   = uif && ie;
endmodule

// File: rtl/pscl_timebase_chk.sv
module pscl_timebase_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic         run,
  input logic         blk,
  input logic         uif,
  input logic [W-1:0] cnt,
  input logic [W-1:0] div_act,
  input logic [W-1:0] top_act,
  input logic         upd_evt,
  input logic         upd_pulse
);
  wire cnt_wr  = wr_en && wr_addr == 3'd3;
  wire ug_try  = wr_en && wr_addr == 3'd2 && wr_data[0];
  wire clr_wr  = wr_en && wr_addr == 3'd1 && !wr_data[0];

  // R8
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !(ug_try && !blk)) |=> $stable(cnt));

  // R7
  p_block_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !uif) |=> !uif);

  // R4
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> ($stable(div_act) && $stable(top_act)));

  // R5
  p_force_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ug_try && !blk) |=> (cnt == '0 && upd_pulse && uif));

  // R10
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uif && !clr_wr) |=> uif);

  // R3
  p_pulse_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> uif);
endmodule

bind pscl_timebase pscl_timebase_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .run(run), .blk(blk), .uif(uif), .cnt(cnt),
  .div_act(div_act), .top_act(top_act), .upd_evt(upd_evt),
  .upd_pulse(upd_pulse)
);

// File: tb/pscl_timebase_bench.sv
`timescale 1ns/1ps
module pscl_timebase_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, count_o;
  logic        upd_pulse, upd_irq;

  pscl_timebase u_pscl_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count_o(count_o), .upd_pulse(upd_pulse), .upd_irq(upd_irq));

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit m_run, m_blk, m_ie, m_uif, m_pulse;
  logic [15:0] m_divp, m_topp, m_diva, m_topa, m_dc, m_cnt;

  task automatic model_reset();
    m_run = 0; m_blk = 0; m_ie = 0; m_uif = 0; m_pulse = 0;
    m_divp = 0; m_diva = 0; m_topp = 16'hFFFF; m_topa = 16'hFFFF;
    m_dc = 0; m_cnt = 0;
  endtask

  function automatic logic [15:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return {13'b0, m_ie, m_blk, m_run};
      3'd1: return {15'b0, m_uif};
      3'd3: return m_cnt;
      3'd4: return m_divp;
      3'd5: return m_topp;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_step(input bit we, input logic [2:0] a, input logic [15:0] d);
    bit tick, wrap, ug, upd;
    tick = m_run && (m_dc == m_diva);
    wrap = tick && (m_cnt == m_topa);
    ug   = we && a == 3'd2 && d[0] && !m_blk;
    upd  = ug || (wrap && !m_blk);
    m_pulse = upd;
    if (upd) m_uif = 1;
    else if (we && a == 3'd1 && !d[0]) m_uif = 0;
    if (we && a == 3'd3) m_cnt = d;
    else if (ug || wrap) m_cnt = 0;
    else if (tick) m_cnt = m_cnt + 16'd1;
    if (ug || tick) m_dc = 0;
    else if (m_run) m_dc = m_dc + 16'd1;
    if (upd) begin m_diva = m_divp; m_topa = m_topp; end
    if (we && a == 3'd4) m_divp = d;
    if (we && a == 3'd5) m_topp = d;
    if (we && a == 3'd0) begin m_run = d[0]; m_blk = d[1]; m_ie = d[2]; end
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] a, input logic [15:0] d, input string tag);
    logic [2:0] ra;
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_step(we, a, d);
    @(negedge clk);
    wr_en = 0;
    ra = 3'($urandom_range(0, 7));
    rd_addr = ra;
    #0.1;
    chk({tag, " count"}, count_o, m_cnt);
    chk({tag, " pulse"}, {15'b0, upd_pulse}, {15'b0, m_pulse});
    chk({tag, " irq R11"}, {15'b0, upd_irq}, {15'b0, m_uif & m_ie});
    chk("R12 read", rd_data, mread(ra));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 3'd0, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #0.1;
      chk("R1 reset read", rd_data, mread(3'(a)));
    end
    chk("R1 count", count_o, 16'h0);
    chk("R1 irq", {15'b0, upd_irq}, 16'h0);

    // R4 preload readback, old divider still active
    cyc(1, 3'd5, 16'd5, "R4");
    cyc(1, 3'd4, 16'd1, "R4");
    rd_addr = 3'd4; #0.1; chk("R4 div readback", rd_data, 16'd1);
    cyc(1, 3'd0, 16'h0005, "R8");
    idle(4, "R4");
    chk("R4 old div rate", count_o, 16'd4);

    // R5 forced update
    cyc(1, 3'd2, 16'h1, "R5");
    chk("R5 count cleared", count_o, 16'd0);
    chk("R5 pulse", {15'b0, upd_pulse}, 16'd1);
    chk("R5 irq", {15'b0, upd_irq}, 16'd1);

    // R2/R3 new rate and wrap at 5
    idle(12, "R3");
    chk("R3 wrap count", count_o, 16'd0);
    chk("R3 wrap pulse", {15'b0, upd_pulse}, 16'd1);
    idle(1, "R3");
    chk("R3 pulse one cycle", {15'b0, upd_pulse}, 16'd0);

    // R8 freeze and resume
    idle(3, "R2");
    cyc(1, 3'd0, 16'h0004, "R8");
    idle(6, "R8");
    chk("R8 frozen", count_o, m_cnt);
    cyc(1, 3'd0, 16'h0005, "R8");
    idle(4, "R8");

    // R10 flag clearing
    cyc(1, 3'd0, 16'h0004, "R10");
    cyc(1, 3'd1, 16'h1, "R10");
    chk("R10 write1 keeps", {15'b0, upd_irq}, 16'd1);
    cyc(1, 3'd1, 16'h0, "R10");
    chk("R10 cleared", {15'b0, upd_irq}, 16'd0);

    // R6 blocked forced update
    cyc(1, 3'd3, 16'd3, "R9");
    chk("R9 count write", count_o, 16'd3);
    cyc(1, 3'd0, 16'h0006, "R6");
    cyc(1, 3'd5, 16'd2, "R6");
    cyc(1, 3'd2, 16'h1, "R6");
    chk("R6 count kept", count_o, 16'd3);
    chk("R6 no pulse", {15'b0, upd_pulse}, 16'd0);
    rd_addr = 3'd1; #0.1; chk("R6 no flag", rd_data, 16'd0);

    // R7 blocked wrap: top stays 5 although pending 2
    cyc(1, 3'd0, 16'h0007, "R7");
    idle(12, "R7");
    rd_addr = 3'd1; #0.1; chk("R7 no flag", rd_data, 16'd0);

    // R9 write wins over tick: hit every phase
    cyc(1, 3'd0, 16'h0005, "R9");
    for (int i = 0; i < 4; i++) begin
      cyc(1, 3'd3, 16'd1, "R9");
      chk("R9 write priority", count_o, 16'd1);
      idle(i, "R9");
    end

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [2:0] a; logic [15:0] d;
        a = 3'($urandom_range(0, 5));
        case (a)
          3'd0: d = {13'b0, 1'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) != 0)};
          3'd3: d = 16'($urandom_range(0, 7));
          3'd4: d = 16'($urandom_range(0, 3));
          3'd5: d = 16'($urandom_range(1, 15));
          default: d = 16'($urandom_range(0, 1));
        endcase
        cyc(1, a, d, "R2 random");
      end else idle(1, "R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule